// File: doc/BRIEF.md
# EDO DRAM Controller with CAS-before-RAS Refresh

This block connects a simple synchronous host request port to one 16-bit EDO asynchronous DRAM. The host presents a 22-bit word address, write data, two byte enables and a read/write flag. The request is taken when valid and ready are both high. The controller splits the address into a 12-bit row and a 10-bit column. It drives them in turn on a shared 12-bit address bus under the row strobe and the two byte-lane column strobes. Every device timing is a parameter given in nanoseconds. Each one is converted to whole clock cycles by rounding up.

After an access the row stays open. A later request to the same row is served by pulsing the column strobes alone. A request to a different row first closes the open row, waits out the precharge, and then opens the new row. A free-running timer raises a refresh request at a fixed interval. Refresh is only taken at an access boundary. The open row is closed and precharged, then a CAS-before-RAS cycle is run, in which the device supplies the row from its own counter.

Top module: `edo_dram_ctrl`

## Requirements
- R1: At the row strobe fall the address bus carries request address bits [21:10]. At the column strobe fall it carries {2'b00, address bits [9:0]}.
- R2: Byte enable bit 0 drives the lower-lane strobe (data bits 7:0) and bit 1 drives the upper-lane strobe (data bits 15:8). Only enabled lanes are written. A request with both enables low writes nothing.
- R3: Read data is captured one cycle after the CAS access count expires. It is returned on rsp_rdata_o together with a single-cycle rsp_valid_o pulse.
- R4: A request to the row that is currently open does not cause a new row-strobe activation.
- R5: A request to a different row closes the open row and opens the new one. Before every row-strobe fall, the row strobe has been high for at least the precharge count.
- R6: Row-to-column delay, minimum row-strobe low time and column-strobe precharge between columns are each met in whole cycles.
- R7: One CAS-before-RAS refresh is issued per refresh interval, which is REF_NS rounded up to cycles.
- R8: In a refresh cycle both column strobes are low for at least the CAS-setup count before the row strobe falls, and write enable is high. A column strobe never falls alone while the row strobe is high.
- R9: While a refresh is pending req_ready_o is low. Refresh is not starved by a continuous request stream.
- R10: Output enable is low only during read column accesses. The data bus is driven only while write enable is low.
- R11: After reset all strobes are high, req_ready_o is high and rsp_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller can take a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 22 | Word address |
| req_wdata_i | input | 16 | Write data |
| req_be_i | input | 2 | Byte enables (bit 0 low lane, bit 1 high lane) |
| rsp_valid_o | output | 1 | Read data valid pulse |
| rsp_rdata_o | output | 16 | Read data |
| dram_addr_o | output | 12 | Multiplexed row/column address |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_lcas_no | output | 1 | Lower-lane column strobe, active low |
| dram_ucas_no | output | 1 | Upper-lane column strobe, active low |
| dram_we_no | output | 1 | Write enable, active low |
| dram_oe_no | output | 1 | Output enable, active low |
| dram_dq_o | output | 16 | Write data to the DRAM |
| dram_dq_oe_o | output | 1 | Data bus drive enable |
| dram_dq_i | input | 16 | Read data from the DRAM |

## Verification
The precharge check assumes the device starts precharged after reset, so its row-strobe high counter begins saturated. The read-capture checks assume the memory returns valid data only after the full CAS access count. The bench's DRAM model drives garbage before that count, so an early capture is detected. The properties also take for granted that the host raises a request only when ready is high and does not depend on a response before it issues the next request. The bench drives inputs at falling edges, waits for ready, and keeps at most one read outstanding.

// File: rtl/edo_pkg.sv
package edo_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ACT,
    ST_OPEN,
    ST_CAS,
    ST_SAMPLE,
    ST_CP,
    ST_CLOSE,
    ST_PRE,
    ST_CBR_CSR,
    ST_CBR_RAS
  } edo_state_e;

  // nanoseconds -> whole cycles, rounded up, at least one
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ps);
    int unsigned c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/edo_wait_cnt.sv
module edo_wait_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/edo_sat_cnt.sv
module edo_sat_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_o <= '0;
    else if (clr_i)                   cnt_o <= '0;
    else if (inc_i && (cnt_o != '1))  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/edo_ref_timer.sv
module edo_ref_timer #(
  parameter int unsigned REF_CYC = 3120
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic pend_o
);
  localparam int unsigned TW = (REF_CYC > 1) ? $clog2(REF_CYC) : 1;

  logic [TW-1:0] tmr_q;
  logic          tick;

  assign tick = (tmr_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   tmr_q <= TW'(REF_CYC - 1);
    else if (tick) tmr_q <= TW'(REF_CYC - 1);
    else           tmr_q <= tmr_q - 1'b1;
  end

  // a new tick wins over an ack in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_o <= 1'b0;
    else if (tick)  pend_o <= 1'b1;
    else if (ack_i) pend_o <= 1'b0;
  end
endmodule

// File: rtl/edo_addr_mux.sv
module edo_addr_mux #(
  parameter int unsigned AW   = 22,
  parameter int unsigned COLW = 10,
  parameter int unsigned MAW  = 12
) (
  input  logic [AW-1:0]      addr_i,
  input  logic               col_sel_i,
  output logic [AW-COLW-1:0] row_o,
  output logic [MAW-1:0]     addr_o
);
  assign row_o  = addr_i[AW-1:COLW];
  assign addr_o = col_sel_i ? MAW'(addr_i[COLW-1:0]) : MAW'(row_o);
endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl
  import edo_pkg::*;
#(
  parameter int unsigned CLK_PS   = 5000,
  parameter int unsigned T_RCD_NS = 20,
  parameter int unsigned T_CAC_NS = 15,
  parameter int unsigned T_CP_NS  = 10,
  parameter int unsigned T_RP_NS  = 40,
  parameter int unsigned T_RAS_NS = 60,
  parameter int unsigned T_CSR_NS = 10,
  parameter int unsigned REF_NS   = 15600,
  parameter int unsigned AW       = 22,
  parameter int unsigned DW       = 16,
  parameter int unsigned COLW     = 10,
  parameter int unsigned MAW      = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_valid_i,
  output logic           req_ready_o,
  input  logic           req_we_i,
  input  logic [AW-1:0]  req_addr_i,
  input  logic [DW-1:0]  req_wdata_i,
  input  logic [1:0]     req_be_i,
  output logic           rsp_valid_o,
  output logic [DW-1:0]  rsp_rdata_o,
  output logic [MAW-1:0] dram_addr_o,
  output logic           dram_ras_no,
  output logic           dram_lcas_no,
  output logic           dram_ucas_no,
  output logic           dram_we_no,
  output logic           dram_oe_no,
  output logic [DW-1:0]  dram_dq_o,
  output logic           dram_dq_oe_o,
  input  logic [DW-1:0]  dram_dq_i
);
  localparam int unsigned ROWW   = AW - COLW;
  localparam int unsigned RCD_C  = ns2cyc(T_RCD_NS, CLK_PS);
  localparam int unsigned CAC_C  = ns2cyc(T_CAC_NS, CLK_PS);
  localparam int unsigned CP_C   = ns2cyc(T_CP_NS,  CLK_PS);
  localparam int unsigned RP_C   = ns2cyc(T_RP_NS,  CLK_PS);
  localparam int unsigned RAS_C  = ns2cyc(T_RAS_NS, CLK_PS);
  localparam int unsigned CSR_C  = ns2cyc(T_CSR_NS, CLK_PS);
  localparam int unsigned REF_C  = ns2cyc(REF_NS,   CLK_PS);
  localparam int unsigned MAXD   = RCD_C + CAC_C + CP_C + RP_C + RAS_C + CSR_C;
  localparam int unsigned CW     = $clog2(MAXD + 1);
  localparam int unsigned AGEW   = $clog2(RAS_C + 1) + 1;

  edo_state_e st_q, st_n;

  logic            we_q;
  logic [1:0]      be_q;
  logic [DW-1:0]   wdata_q;
  logic [AW-1:0]   addr_q;
  logic [ROWW-1:0] open_row_q;
  logic            ref_after_q;
  logic            miss_q;
  logic            rsp_q;
  logic [DW-1:0]   rdata_q;

  logic            ref_pend;
  logic            ref_ack;
  logic            wait_done;
  logic            wait_load;
  logic [CW-1:0]   wait_val;
  int unsigned     dur;
  logic            ras_low;
  logic            col_phase;
  logic            col_strobe;
  logic [AGEW-1:0] ras_age;
  logic            ras_age_ok;
  logic [ROWW-1:0] req_row;
  logic [ROWW-1:0] q_row;
  logic            accept;
  logic            row_hit;

  assign req_row = req_addr_i[AW-1:COLW];

  // ---------------- sub-blocks ----------------
  edo_ref_timer #(.REF_CYC(REF_C)) u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ack_i  (ref_ack),
    .pend_o (ref_pend)
  );

  edo_wait_cnt #(.W(CW)) u_wait (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wait_load),
    .load_val_i (wait_val),
    .done_o     (wait_done)
  );

  edo_sat_cnt #(.W(AGEW)) u_age (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!ras_low),
    .inc_i  (ras_low),
    .cnt_o  (ras_age)
  );

  edo_addr_mux #(.AW(AW), .COLW(COLW), .MAW(MAW)) u_amux (
    .addr_i    (addr_q),
    .col_sel_i (col_phase),
    .row_o     (q_row),
    .addr_o    (dram_addr_o)
  );

  // ---------------- handshake ----------------
  assign req_ready_o = ((st_q == ST_IDLE) || (st_q == ST_OPEN)) && !ref_pend;
  assign accept      = req_valid_i && req_ready_o;
  assign row_hit     = (req_row == open_row_q);
  assign ras_age_ok  = (ras_age >= AGEW'(RAS_C - 1));

  // ---------------- sequencer ----------------
  always_comb begin
    st_n = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (ref_pend)    st_n = ST_CBR_CSR;
        else if (accept) st_n = ST_ACT;
      end
      ST_ACT:    if (wait_done) st_n = ST_CAS;
      ST_CAS:    if (wait_done) st_n = ST_SAMPLE;
      ST_SAMPLE: st_n = ST_CP;
      ST_CP:     if (wait_done) st_n = ST_OPEN;
      ST_OPEN: begin
        if (ref_pend)    st_n = ST_CLOSE;
        else if (accept) st_n = row_hit ? ST_CAS : ST_CLOSE;
      end
      ST_CLOSE:  if (ras_age_ok) st_n = ST_PRE;
      ST_PRE: begin
        if (wait_done) begin
          if (ref_after_q) st_n = ST_CBR_CSR;
          else if (miss_q) st_n = ST_ACT;
          else             st_n = ST_IDLE;
        end
      end
      ST_CBR_CSR: if (wait_done) st_n = ST_CBR_RAS;
      ST_CBR_RAS: if (wait_done) st_n = ST_PRE;
      default:    st_n = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (st_n)
      ST_ACT:     dur = RCD_C;
      ST_CAS:     dur = CAC_C;
      ST_CP:      dur = CP_C;
      ST_PRE:     dur = RP_C;
      ST_CBR_CSR: dur = CSR_C;
      ST_CBR_RAS: dur = RAS_C;
      default:    dur = 1;
    endcase
  end

  assign wait_load = (st_n != st_q);
  assign wait_val  = CW'(dur - 1);
  assign ref_ack   = (st_n == ST_CBR_CSR) && (st_q != ST_CBR_CSR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_n;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      be_q    <= 2'b00;
      wdata_q <= '0;
      addr_q  <= '0;
    end else if (accept) begin
      we_q    <= req_we_i;
      be_q    <= req_be_i;
      wdata_q <= req_wdata_i;
      addr_q  <= req_addr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_row_q  <= '0;
      ref_after_q <= 1'b0;
      miss_q      <= 1'b0;
    end else begin
      if ((st_q != ST_ACT) && (st_n == ST_ACT)) open_row_q <= q_row_next();
      if ((st_q == ST_OPEN) && (st_n == ST_CLOSE)) begin
        ref_after_q <= ref_pend;
        miss_q      <= !ref_pend;
      end
      if (ref_ack) ref_after_q <= 1'b0;
      if ((st_q == ST_PRE) && (st_n != ST_PRE)) miss_q <= 1'b0;
    end
  end

  // row that ACT will open: new request from IDLE, latched request otherwise
  function automatic logic [ROWW-1:0] q_row_next();
    return (st_q == ST_IDLE) ? req_row : q_row;
  endfunction

  // ---------------- read capture ----------------
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      rsp_q <= (st_q == ST_SAMPLE) && !we_q;
      if ((st_q == ST_SAMPLE) && !we_q) rdata_q <= dram_dq_i;
    end
  end

  assign rsp_valid_o = rsp_q;
  assign rsp_rdata_o = rdata_q;

  // ---------------- pin decode ----------------
  assign ras_low    = (st_q == ST_ACT) || (st_q == ST_OPEN) || (st_q == ST_CAS) ||
                      (st_q == ST_SAMPLE) || (st_q == ST_CP) || (st_q == ST_CLOSE) ||
                      (st_q == ST_CBR_RAS);
  assign col_strobe = (st_q == ST_CAS) || (st_q == ST_SAMPLE);
  assign col_phase  = col_strobe || (st_q == ST_CP);

  always_comb begin
    dram_ras_no  = !ras_low;
    dram_lcas_no = 1'b1;
    dram_ucas_no = 1'b1;
    dram_we_no   = 1'b1;
    dram_oe_no   = 1'b1;
    if (col_strobe) begin
      dram_lcas_no = !be_q[0];
      dram_ucas_no = !be_q[1];
      dram_we_no   = !we_q;
      dram_oe_no   = we_q;
    end else if ((st_q == ST_CBR_CSR) || (st_q == ST_CBR_RAS)) begin
      dram_lcas_no = 1'b0;
      dram_ucas_no = 1'b0;
    end
  end

  assign dram_dq_o    = wdata_q;
  assign dram_dq_oe_o = !dram_we_no;

endmodule

// File: rtl/edo_dram_ctrl_chk.sv
module edo_dram_ctrl_chk #(
  parameter int unsigned RP_C = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ras_n,
  input logic lcas_n,
  input logic ucas_n,
  input logic we_n,
  input logic oe_n,
  input logic dq_oe,
  input logic ready,
  input logic rsp_valid,
  input logic ref_pend
);
  localparam int unsigned HW = $clog2(RP_C + 1) + 1;

  logic [HW-1:0] hi_cnt;

  // device assumed precharged at power-up: start saturated
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                hi_cnt <= '1;
    else if (!ras_n)            hi_cnt <= '0;
    else if (hi_cnt != '1)      hi_cnt <= hi_cnt + 1'b1;
  end

  // R5
  precharge_met_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n) |-> (hi_cnt >= HW'(RP_C)));

  // R8
  cbr_both_lanes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_n) && (!lcas_n || !ucas_n)) |-> (!lcas_n && !ucas_n && we_n));

  // R8
  no_lone_cas_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_n && (!lcas_n || !ucas_n)) |-> (!lcas_n && !ucas_n));

  // R10
  oe_read_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_n |-> (we_n && (!lcas_n || !ucas_n)));

  // R10
  bus_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe |-> (oe_n && !ras_n));

  // R3
  rsp_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid |=> !rsp_valid);

  // R9
  ref_blocks_host_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_pend |-> !ready);

  // R11
  ready_strobes_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready |-> (lcas_n && ucas_n && we_n && oe_n));
endmodule

bind edo_dram_ctrl edo_dram_ctrl_chk #(.RP_C(RP_C)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ras_n     (dram_ras_no),
  .lcas_n    (dram_lcas_no),
  .ucas_n    (dram_ucas_no),
  .we_n      (dram_we_no),
  .oe_n      (dram_oe_no),
  .dq_oe     (dram_dq_oe_o),
  .ready     (req_ready_o),
  .rsp_valid (rsp_valid_o),
  .ref_pend  (ref_pend)
);

// File: tb/edo_dram_ctrl_tb.sv
module edo_dram_ctrl_tb;
  localparam int unsigned CLK_PS = 5000;
  localparam int unsigned REF_NS = 3000;

  function automatic int unsigned cyc(input int unsigned ns);
    int unsigned c;
    c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
    return (c == 0) ? 1 : c;
  endfunction

  localparam int unsigned RCD_C = cyc(20);
  localparam int unsigned CAC_C = cyc(15);
  localparam int unsigned CP_C  = cyc(10);
  localparam int unsigned RP_C  = cyc(40);
  localparam int unsigned RAS_C = cyc(60);
  localparam int unsigned CSR_C = cyc(10);
  localparam int unsigned REF_C = cyc(REF_NS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        valid = 1'b0, we = 1'b0;
  logic [21:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  be = 2'b00;
  logic        ready, rsp;
  logic [15:0] rdata;
  logic [11:0] a;
  logic        ras_n, l_n, u_n, we_n, oe_n, dq_oe;
  logic [15:0] dq_o, dq_i;

  edo_dram_ctrl #(.CLK_PS(CLK_PS), .REF_NS(REF_NS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(valid), .req_ready_o(ready), .req_we_i(we),
    .req_addr_i(addr), .req_wdata_i(wdata), .req_be_i(be),
    .rsp_valid_o(rsp), .rsp_rdata_o(rdata),
    .dram_addr_o(a), .dram_ras_no(ras_n), .dram_lcas_no(l_n), .dram_ucas_no(u_n),
    .dram_we_no(we_n), .dram_oe_no(oe_n), .dram_dq_o(dq_o), .dram_dq_oe_o(dq_oe),
    .dram_dq_i(dq_i)
  );

  int checks = 0, errors = 0;
  int unsigned cycle = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------------- DRAM model ----------------
  logic [15:0] mem [int unsigned];
  logic [15:0] shadow [int unsigned];
  logic [11:0] cur_row = '0;
  logic [9:0]  last_col = '0;
  logic [15:0] rd_word = '0;
  logic        p_ras = 1'b1, p_l = 1'b1, p_u = 1'b1;
  int unsigned ras_hi, ras_lo, cas_hi, cas_blo, cas_cyc;
  int unsigned act_cnt = 0, cbr_cnt = 0;
  int unsigned v_rp = 0, v_rcd = 0, v_ras = 0, v_cp = 0, v_csr = 0, v_ord = 0, v_oe = 0;
  logic        cas_now, cas_prev;
  logic [15:0] w;
  int unsigned key;

  assign dq_i = (!oe_n && cas_cyc >= CAC_C) ? rd_word : 16'hBAD1;

  always @(posedge clk) begin
    cycle <= cycle + 1;
    if (!rst_n) begin
      p_ras <= 1'b1; p_l <= 1'b1; p_u <= 1'b1;
      ras_hi <= 1000; ras_lo <= 0; cas_hi <= 1000; cas_blo <= 0; cas_cyc <= 0;
    end else begin
      cas_now  = !l_n || !u_n;
      cas_prev = !p_l || !p_u;
      if (p_ras && !ras_n) begin
        if (ras_hi < RP_C) v_rp++;
        if (!l_n && !u_n) begin
          cbr_cnt++;
          if (cas_blo < CSR_C) v_csr++;
          if (!we_n) v_ord++;
        end else if (cas_now) v_ord++;
        else begin
          act_cnt++;
          cur_row <= a;
        end
      end
      if (!p_ras && ras_n && ras_lo < RAS_C) v_ras++;
      if (cas_now && !cas_prev && ras_n && !(!l_n && !u_n)) v_ord++;
      if (cas_now && !cas_prev && !ras_n) begin
        if (ras_lo < RCD_C) v_rcd++;
        if (cas_hi < CP_C) v_cp++;
        key = {cur_row, a[9:0]};
        w = mem.exists(key) ? mem[key] : 16'h0000;
        if (!we_n) begin
          if (!l_n) w[7:0]  = dq_o[7:0];
          if (!u_n) w[15:8] = dq_o[15:8];
          mem[key] = w;
        end
        last_col <= a[9:0];
        rd_word  <= w;
      end
      if (!oe_n && !we_n) v_oe++;
      if (dq_oe && (we_n || !oe_n)) v_oe++;
      ras_hi  <= ras_n ? ras_hi + 1 : 0;
      ras_lo  <= ras_n ? 0 : ras_lo + 1;
      cas_hi  <= (l_n && u_n) ? cas_hi + 1 : 0;
      cas_blo <= (!l_n && !u_n) ? cas_blo + 1 : 0;
      cas_cyc <= cas_now ? cas_cyc + 1 : 0;
      p_ras <= ras_n; p_l <= l_n; p_u <= u_n;
    end
  end

  // ---------------- host tasks ----------------
  task automatic host_req(input bit w_e, input logic [21:0] ad, input logic [15:0] d, input logic [1:0] b);
    @(negedge clk);
    while (!ready) @(negedge clk);
    valid = 1'b1; we = w_e; addr = ad; wdata = d; be = b;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic wr(input logic [21:0] ad, input logic [15:0] d, input logic [1:0] b);
    logic [15:0] s;
    s = shadow.exists(int'(ad)) ? shadow[int'(ad)] : 16'h0000;
    if (b[0]) s[7:0]  = d[7:0];
    if (b[1]) s[15:8] = d[15:8];
    shadow[int'(ad)] = s;
    host_req(1'b1, ad, d, b);
  endtask

  task automatic rd(input logic [21:0] ad, input string req);
    logic [15:0] e;
    e = shadow.exists(int'(ad)) ? shadow[int'(ad)] : 16'h0000;
    host_req(1'b0, ad, 16'h0, 2'b11);
    while (!rsp) @(negedge clk);
    chk(rdata == e, req, rdata, e);
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
    while (!ready) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  always @(negedge clk) begin
    if (cycle > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected <150000", cycle);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int unsigned a0, c0, t0, exp_ref;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(ras_n && l_n && u_n && we_n && oe_n, "R11 strobes", {ras_n, l_n, u_n, we_n, oe_n}, 5'h1f);
    chk(!rsp, "R11 rsp", rsp, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready, "R11 ready", ready, 1);

    // R4/R2: page-hit write sweep, four rows x eight columns
    for (int r = 0; r < 4; r++) begin
      a0 = act_cnt; c0 = cbr_cnt;
      for (int c = 0; c < 8; c++)
        wr(22'((r << 10) | c), 16'(16'h1000 + r * 256 + c * 17), 2'b11);
      settle();
      chk((act_cnt - a0) >= 1 && (act_cnt - a0) <= 1 + (cbr_cnt - c0),
          "R4 page writes", act_cnt - a0, 1 + (cbr_cnt - c0));
    end

    // R2: byte lanes on row 6
    for (int c = 0; c < 4; c++) begin
      wr(22'((6 << 10) | c), 16'hA5C3, 2'b11);
      wr(22'((6 << 10) | c), 16'(16'h1200 + c), 2'(c));
    end
    for (int c = 0; c < 4; c++) rd(22'((6 << 10) | c), "R2 byte lanes");

    // R5/R3/R1: column-major reads, every read a row miss
    a0 = act_cnt;
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 4; r++)
        rd(22'((r << 10) | c), "R3 miss read");
    chk(act_cnt - a0 == 32, "R5 miss activations", act_cnt - a0, 32);

    // R4: page-hit reads on row 2
    settle();
    a0 = act_cnt; c0 = cbr_cnt;
    for (int c = 0; c < 8; c++) rd(22'((2 << 10) | c), "R3 hit read");
    chk((act_cnt - a0) >= 1 && (act_cnt - a0) <= 1 + (cbr_cnt - c0),
        "R4 page reads", act_cnt - a0, 1 + (cbr_cnt - c0));

    // R1: address extremes
    wr(22'h3FFFFF, 16'hBEEF, 2'b11);
    wr(22'h3FFC00, 16'h0F0F, 2'b11);
    wr(22'h0003FF, 16'h7E57, 2'b11);
    rd(22'h0003FF, "R1 low row high col");
    rd(22'h3FFC00, "R1 high row col 0");
    rd(22'h3FFFFF, "R1 top word");
    chk(cur_row == 12'hFFF, "R1 row bus", cur_row, 12'hFFF);
    chk(last_col == 10'h3FF, "R1 col bus", last_col, 10'h3FF);

    // R7: refresh rate while idle
    settle();
    c0 = cbr_cnt;
    repeat (REF_C * 5) @(negedge clk);
    chk((cbr_cnt - c0) >= 4 && (cbr_cnt - c0) <= 6, "R7 idle refresh", cbr_cnt - c0, 5);

    // R9: refresh under continuous traffic
    c0 = cbr_cnt; t0 = cycle;
    for (int i = 0; i < 100; i++) rd(22'(((i % 3) << 10) | (i % 8)), "R9 busy read");
    exp_ref = (cycle - t0) / REF_C;
    chk((cbr_cnt - c0) + 1 >= exp_ref, "R9 refresh not starved", cbr_cnt - c0, exp_ref);

    // R6/R8/R10: timing and ordering tallies from the device model
    settle();
    chk(v_rcd == 0, "R6 row-to-column", v_rcd, 0);
    chk(v_ras == 0, "R6 row low time", v_ras, 0);
    chk(v_cp == 0, "R6 column precharge", v_cp, 0);
    chk(v_rp == 0, "R5 row precharge", v_rp, 0);
    chk(v_csr == 0, "R8 CAS setup", v_csr, 0);
    chk(v_ord == 0, "R8 strobe order", v_ord, 0);
    chk(v_oe == 0, "R10 bus control", v_oe, 0);
    chk(cbr_cnt > 0, "R7 refresh seen", cbr_cnt, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule